// File: doc/BRIEF.md
# Way-Tagged L2 Access Controller

This controller sits between a processor and a two-level cache made of a direct-mapped L1 data store and a 4-way set-associative L2 store. L1 uses write-through, so every processor store also writes L2 and main memory. L2 is inclusive, so any line in L1 also has a copy in L2. When a line enters L1, the controller records which L2 way holds its copy. A later store that hits in L1 can then write L2 through that single way, as a direct-mapped store would. Lookups with no way tag available enable and compare all L2 ways together.

Requests are handled one at a time under a valid/ready handshake. A read that misses both levels goes to memory, and the controller stays not ready until the response arrives. The fill chooses its L2 victim round-robin per set. If the victim line is also held in L1, that L1 copy is invalidated, so no L1 entry keeps a way tag that points at a reused way. Each accepted request reports which L2 ways its lookup enabled and how many, so the energy-relevant access pattern can be seen at the ports.

Top module: `wt_l2_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid, acc_valid and mem_valid are 0, and both caches are empty. While req_ready is 0, no request is accepted.
- R2: A read that hits L1 enables no L2 way (acc_ways = 0, acc_way_en = 0). It returns the line's data with resp_valid in the cycle after acceptance and issues no memory access.
- R3: A write that hits L1 enables exactly one L2 way (acc_ways = 1). acc_way_en is one-hot, with bit w set for L2 way w, and w is the way recorded when the line was filled.
- R4: Any request that misses L1 enables all L2 ways (acc_ways = 4, acc_way_en = 4'b1111).
- R5: When a line is filled into L1, the index of the L2 way holding its copy is stored as its way tag. The way is the hitting way on an L2 hit and the victim way on an L2 miss.
- R6: Each L2 set keeps a 2-bit round-robin pointer, starting at 0, that picks the victim of each L2 miss fill and then advances by one, modulo 4. Successive fills of one set therefore use ways 0, 1, 2, 3, 0.
- R7: Every accepted write issues, in the following cycle, a one-cycle memory write (mem_valid = 1, mem_we = 1) carrying the request's address and data.
- R8: A read missing both L1 and L2 issues a one-cycle memory read (mem_valid = 1, mem_we = 0) with the request address. req_ready stays 0 until mem_rvalid. In the cycle after mem_rvalid, resp_valid returns mem_rdata and the line is installed in L2 and L1.
- R9: When an L2 fill evicts a line that is also held in L1, that L1 entry is invalidated. A later read of the evicted address misses L1 and is refetched from memory.
- R10: A write that misses L1 does not allocate in L1. If the line is in L2, the L2 copy is updated through the way that matched.
- R11: Every read returns the value most recently written to its address, or the memory contents if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Read data valid (one cycle) |
| resp_rdata | output | DATA_W | Read data |
| acc_valid | output | 1 | Lookup report valid, one cycle after acceptance |
| acc_way_en | output | L2_WAYS | L2 ways enabled by the lookup |
| acc_ways | output | CNT_W | Number of L2 ways enabled |
| mem_valid | output | 1 | Memory request pulse |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Memory read response valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The checker watches the relations that hold in every cycle. These are: L1 read hits answer at once with no way enabled, a single-way lookup is one-hot and always comes with a memory write, a full lookup enables every way, and the controller stays closed from a memory read until its response. Whether the enabled way is the right one, whether round-robin order and back-invalidation happen, and whether the data returned is current all depend on history. Only the bench's directed set-conflict sequences and its random traffic over a small address range, checked against a reference model, can show those.

// File: rtl/wt_l2_ctrl.sv
module wt_l2_ctrl #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int L1_SETS = 8,
  parameter int L2_SETS = 4,
  parameter int L2_WAYS = 4,
  localparam int L1_IW  = $clog2(L1_SETS),
  localparam int L2_SW  = $clog2(L2_SETS),
  localparam int WAY_W  = $clog2(L2_WAYS),
  localparam int CNT_W  = $clog2(L2_WAYS + 1),
  localparam int L1_TW  = ADDR_W - L1_IW,
  localparam int L2_TW  = ADDR_W - L2_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              acc_valid,
  output logic [L2_WAYS-1:0] acc_way_en,
  output logic [CNT_W-1:0]  acc_ways,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              l1_vld [L1_SETS];
  logic [L1_TW-1:0]  l1_tag [L1_SETS];
  logic [WAY_W-1:0]  l1_way [L1_SETS];
  logic [DATA_W-1:0] l1_dat [L1_SETS];

  logic              l2_vld [L2_SETS][L2_WAYS];
  logic [L2_TW-1:0]  l2_tag [L2_SETS][L2_WAYS];
  logic [DATA_W-1:0] l2_dat [L2_SETS][L2_WAYS];
  logic [WAY_W-1:0]  rr     [L2_SETS];

  logic              filling;
  logic [ADDR_W-1:0] p_addr;

  wire              fire = req_valid && req_ready;
  wire [L1_IW-1:0]  idx1 = req_addr[L1_IW-1:0];
  wire [L1_TW-1:0]  tag1 = req_addr[ADDR_W-1:L1_IW];
  wire [L2_SW-1:0]  set2 = req_addr[L2_SW-1:0];
  wire [L2_TW-1:0]  tag2 = req_addr[ADDR_W-1:L2_SW];
  wire              l1_hit = l1_vld[idx1] && (l1_tag[idx1] == tag1);

  logic [L2_WAYS-1:0] hit_vec;
  logic [WAY_W-1:0]   hit_way;
  wire                l2_hit = |hit_vec;

  for (genvar w = 0; w < L2_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = l2_vld[set2][w] && (l2_tag[set2][w] == tag2);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < L2_WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  wire [L1_IW-1:0]  p_idx  = p_addr[L1_IW-1:0];
  wire [L1_TW-1:0]  p_t1   = p_addr[ADDR_W-1:L1_IW];
  wire [L2_SW-1:0]  p_set  = p_addr[L2_SW-1:0];
  wire [L2_TW-1:0]  p_t2   = p_addr[ADDR_W-1:L2_SW];
  wire [WAY_W-1:0]  victim = rr[p_set];
  wire [ADDR_W-1:0] v_addr = {l2_tag[p_set][victim], p_set};
  wire [L1_IW-1:0]  v_idx  = v_addr[L1_IW-1:0];
  wire              v_in_l1 = l2_vld[p_set][victim] && l1_vld[v_idx] &&
                              (l1_tag[v_idx] == v_addr[ADDR_W-1:L1_IW]);

  assign req_ready = !filling;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling    <= 1'b0;
      p_addr     <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      acc_valid  <= 1'b0;
      acc_way_en <= '0;
      acc_ways   <= '0;
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      for (int i = 0; i < L1_SETS; i++) begin
        l1_vld[i] <= 1'b0;
        l1_tag[i] <= '0;
        l1_way[i] <= '0;
        l1_dat[i] <= '0;
      end
      for (int s = 0; s < L2_SETS; s++) begin
        rr[s] <= '0;
        for (int w = 0; w < L2_WAYS; w++) begin
          l2_vld[s][w] <= 1'b0;
          l2_tag[s][w] <= '0;
          l2_dat[s][w] <= '0;
        end
      end
    end else begin
      resp_valid <= 1'b0;
      acc_valid  <= 1'b0;
      mem_valid  <= 1'b0;
      if (fire) begin
        acc_valid <= 1'b1;
        if (req_we) begin
          mem_valid <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= req_addr;
          mem_wdata <= req_wdata;
        end
        if (l1_hit && !req_we) begin
          acc_way_en <= '0;
          acc_ways   <= '0;
          resp_valid <= 1'b1;
          resp_rdata <= l1_dat[idx1];
        end else if (l1_hit) begin
          acc_way_en <= {{(L2_WAYS-1){1'b0}}, 1'b1} << l1_way[idx1];
          acc_ways   <= CNT_W'(1);
          l1_dat[idx1] <= req_wdata;
          l2_dat[set2][l1_way[idx1]] <= req_wdata;
        end else begin
          acc_way_en <= '1;
          acc_ways   <= CNT_W'(L2_WAYS);
          if (req_we) begin
            if (l2_hit) l2_dat[set2][hit_way] <= req_wdata;
          end else if (l2_hit) begin
            resp_valid   <= 1'b1;
            resp_rdata   <= l2_dat[set2][hit_way];
            l1_vld[idx1] <= 1'b1;
            l1_tag[idx1] <= tag1;
            l1_way[idx1] <= hit_way;
            l1_dat[idx1] <= l2_dat[set2][hit_way];
          end else begin
            filling   <= 1'b1;
            p_addr    <= req_addr;
            mem_valid <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= req_addr;
          end
        end
      end else if (filling && mem_rvalid) begin
        filling    <= 1'b0;
        resp_valid <= 1'b1;
        resp_rdata <= mem_rdata;
        if (v_in_l1) l1_vld[v_idx] <= 1'b0;
        l2_vld[p_set][victim] <= 1'b1;
        l2_tag[p_set][victim] <= p_t2;
        l2_dat[p_set][victim] <= mem_rdata;
        rr[p_set] <= victim + 1'b1;
        l1_vld[p_idx] <= 1'b1;
        l1_tag[p_idx] <= p_t1;
        l1_way[p_idx] <= victim;
        l1_dat[p_idx] <= mem_rdata;
      end
    end
  end

endmodule

module wt_l2_ctrl_chk #(
  parameter int L2_WAYS = 4,
  localparam int CNT_W  = $clog2(L2_WAYS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               acc_valid,
  input logic [L2_WAYS-1:0] acc_way_en,
  input logic [CNT_W-1:0]   acc_ways,
  input logic               mem_valid,
  input logic               mem_we,
  input logic               mem_rvalid
);

  // R1
  closed_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !acc_valid);

  // R2
  l1_read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ways == '0) |-> (resp_valid && acc_way_en == '0 && !mem_valid));

  // R3
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ways == CNT_W'(1)) |-> ($countones(acc_way_en) == 1));

  // R4
  all_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ways == CNT_W'(L2_WAYS)) |-> (acc_way_en == '1));

  // R7
  write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ways == CNT_W'(1)) |-> (mem_valid && mem_we));

  // R8
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> (!req_ready && !resp_valid));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rvalid) |=> !req_ready);

endmodule

bind wt_l2_ctrl wt_l2_ctrl_chk #(.L2_WAYS(L2_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .acc_valid(acc_valid), .acc_way_en(acc_way_en), .acc_ways(acc_ways),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_rvalid(mem_rvalid)
);

// File: tb/wt_l2_ctrl_bench.sv
module wt_l2_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, acc_valid, mem_valid, mem_we;
  logic [31:0] resp_rdata, mem_wdata;
  logic [3:0]  acc_way_en;
  logic [2:0]  acc_ways;
  logic [11:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0, fails = 0;

  logic [31:0] gold [4096];
  logic        m1_vld [8];
  logic [8:0]  m1_tag [8];
  logic [1:0]  m1_way [8];
  logic        m2_vld [4][4];
  logic [9:0]  m2_tag [4][4];
  logic [1:0]  m2_rr  [4];

  always #4 clk = ~clk;

  wt_l2_ctrl u_wt_l2_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .acc_valid(acc_valid),
    .acc_way_en(acc_way_en), .acc_ways(acc_ways), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(input int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
  endfunction

  task automatic do_req(input bit we, input logic [11:0] addr, input logic [31:0] wd);
    logic [2:0] i1 = addr[2:0];
    logic [8:0] t1 = addr[11:3];
    logic [1:0] s2 = addr[1:0];
    logic [9:0] t2 = addr[11:2];
    bit l1h, l2h;
    logic [1:0] hw;
    int lat;
    l1h = m1_vld[i1] && m1_tag[i1] == t1;
    l2h = 1'b0; hw = '0;
    for (int w = 0; w < 4; w++)
      if (m2_vld[s2][w] && m2_tag[s2][w] == t2) begin l2h = 1'b1; hw = 2'(w); end
    @(negedge clk);
    chk(req_ready, "R1", 32'(req_ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(acc_valid, "R1", 32'(acc_valid), 1);
    if (we) begin
      chk(mem_valid && mem_we && mem_addr == addr && mem_wdata == wd, "R7", mem_wdata, wd);
      gold[addr] = wd;
      if (l1h) begin
        chk(acc_ways == 1, "R3", 32'(acc_ways), 1);
        chk(acc_way_en == 4'(1 << m1_way[i1]), "R3", 32'(acc_way_en), 32'(1 << m1_way[i1]));
      end else begin
        chk(acc_ways == 4 && acc_way_en == 4'hF, "R4", 32'(acc_way_en), 32'hF);
      end
    end else if (l1h) begin
      chk(acc_ways == 0 && acc_way_en == 0 && !mem_valid, "R2", 32'(acc_ways), 0);
      chk(resp_valid && resp_rdata == gold[addr], "R11", resp_rdata, gold[addr]);
    end else begin
      chk(acc_ways == 4 && acc_way_en == 4'hF, "R4", 32'(acc_way_en), 32'hF);
      if (l2h) begin
        chk(resp_valid && !mem_valid && resp_rdata == gold[addr], "R11", resp_rdata, gold[addr]);
        m1_vld[i1] = 1'b1; m1_tag[i1] = t1; m1_way[i1] = hw;
      end else begin
        logic [1:0]  v;
        logic [11:0] va;
        chk(mem_valid && !mem_we && mem_addr == addr && !resp_valid, "R8", 32'(mem_addr), 32'(addr));
        lat = 1 + int'($urandom % 4);
        for (int k = 0; k < lat; k++) begin
          @(posedge clk);
          @(negedge clk);
          chk(!req_ready && !resp_valid, "R8", 32'(req_ready), 0);
        end
        mem_rvalid = 1'b1; mem_rdata = gold[addr];
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(resp_valid && resp_rdata == gold[addr], "R8", resp_rdata, gold[addr]);
        chk(req_ready, "R8", 32'(req_ready), 1);
        v = m2_rr[s2];
        if (m2_vld[s2][v]) begin
          va = {m2_tag[s2][v], s2};
          if (m1_vld[va[2:0]] && m1_tag[va[2:0]] == va[11:3]) m1_vld[va[2:0]] = 1'b0;
        end
        m2_vld[s2][v] = 1'b1; m2_tag[s2][v] = t2; m2_rr[s2] = v + 2'd1;
        m1_vld[i1] = 1'b1; m1_tag[i1] = t1; m1_way[i1] = v;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 4096; a++) gold[a] = init_val(a);
    for (int i = 0; i < 8; i++) begin m1_vld[i] = 1'b0; m1_tag[i] = '0; m1_way[i] = '0; end
    for (int s = 0; s < 4; s++) begin
      m2_rr[s] = '0;
      for (int w = 0; w < 4; w++) begin m2_vld[s][w] = 1'b0; m2_tag[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !resp_valid && !acc_valid && !mem_valid, "R1", 32'(req_ready), 1);

    // R8, R2, R3, R5: fill then hit
    do_req(1'b0, 12'h010, 0);
    do_req(1'b0, 12'h010, 0);
    do_req(1'b1, 12'h010, 32'h1111_2222);
    chk(acc_way_en == 4'b0001, "R5", 32'(acc_way_en), 1);
    do_req(1'b0, 12'h010, 0);

    // R6: round-robin in set 1, R9: back-invalidation
    do_req(1'b0, 12'h001, 0); do_req(1'b1, 12'h001, 32'hA001);
    chk(acc_way_en == 4'b0001, "R6", 32'(acc_way_en), 32'h1);
    do_req(1'b0, 12'h005, 0); do_req(1'b1, 12'h005, 32'hA005);
    chk(acc_way_en == 4'b0010, "R6", 32'(acc_way_en), 32'h2);
    do_req(1'b0, 12'h00D, 0); do_req(1'b1, 12'h00D, 32'hA00D);
    chk(acc_way_en == 4'b0100, "R6", 32'(acc_way_en), 32'h4);
    do_req(1'b0, 12'h015, 0); do_req(1'b1, 12'h015, 32'hA015);
    chk(acc_way_en == 4'b1000, "R6", 32'(acc_way_en), 32'h8);
    do_req(1'b0, 12'h025, 0); do_req(1'b1, 12'h025, 32'hA025);
    chk(acc_way_en == 4'b0001, "R6", 32'(acc_way_en), 32'h1);
    do_req(1'b0, 12'h001, 0);
    chk(acc_ways == 3'd4, "R9", 32'(acc_ways), 4);

    // R10: write miss in L1 with L2 hit, then read sees it through L2
    do_req(1'b1, 12'h00D, 32'hBEEF_000D);
    chk(acc_ways == 3'd4, "R10", 32'(acc_ways), 4);
    do_req(1'b0, 12'h00D, 0);
    chk(acc_ways == 3'd4 && resp_rdata == 32'hBEEF_000D, "R10", resp_rdata, 32'hBEEF_000D);
    // R10: write miss in both levels, no allocation
    do_req(1'b1, 12'h033, 32'h0000_5533);
    do_req(1'b0, 12'h033, 0);
    chk(resp_rdata == 32'h0000_5533, "R11", resp_rdata, 32'h0000_5533);

    for (int n = 0; n < 600; n++) begin
      logic [11:0] a = 12'($urandom % 64);
      do_req(1'($urandom % 2), a, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule